// File: doc/BRIEF.md
# Windowed Register File with Spill and Fill

This block is a register file for a processor that slides a window of registers on every procedure call. Software sees 32 registers through a 5-bit index. Eight of them are globals, common to every frame. The other 24 come from a circular physical store that holds `NWIN` windows. A save strobe (call) moves the current-window pointer forward by one. A restore strobe (return) moves it back. The eight outgoing registers of a caller are the same physical storage as the eight incoming registers of the callee, so arguments pass between frames without being copied.

The circular store holds at most `NWIN-1` frames. A save issued while that many frames are resident raises `overflow`. The block then stalls the save and streams the oldest resident frame out on the spill port, one word per cycle, and the save completes after the last word. A restore issued while only one frame is resident raises `underflow`. The block takes the caller's 16 words from the fill port and then completes the return. Frames leave the store one at a time and come back only when a return needs them. Reads are combinational and see a write made in the same cycle. Memory traffic and trap software sit outside the block.

Top module: `winreg_file`

## Requirements
- R1: Indices 0–7 select globals, which read the same in every window. Indices 8–15 are the frame's outgoing group, 16–23 its locals and 24–31 its incoming group.
- R2: A save that does not overflow increments `cwp` modulo `NWIN`, and a restore that does not underflow decrements it. After a save, indices 24–31 return what indices 8–15 held before the save.
- R3: Index 0 always reads zero on both read ports, and writes to index 0 are discarded.
- R4: A read whose index matches an enabled write in the same cycle returns the data being written.
- R5: A save made while `NWIN-1` frames are resident starts the spill. From the next cycle, `overflow` is high for exactly 16 cycles. During those cycles `xfer_idx` steps 0..15 and `spill_data` carries the oldest frame's locals (`xfer_idx` 0–7), then its incoming group (8–15). `cwp` advances in the cycle after the last word.
- R6: A restore made while one frame is resident starts the fill. From the next cycle, `underflow` stays high until 16 words have been accepted; a word is taken on each cycle with `fill_valid` high. The words are the caller's locals (`xfer_idx` 0–7), then its incoming group (8–15). `cwp` then decrements, and the filled values read back through the caller's indices.
- R7: A save or restore strobe is ignored while `overflow` or `underflow` is high. When both strobes are asserted together, the save is performed and the restore is ignored.
- R8: A save or restore that needs no memory traffic completes at the next edge with no flag raised. An overflow spills exactly one frame, and spilled frames are not brought back until a return finds them missing.
- R9: After reset, `cwp` is 0, one frame is resident, and `overflow` and `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_addr_a | input | 5 | Read port A architectural index |
| rd_data_a | output | DW | Read port A data (combinational) |
| rd_addr_b | input | 5 | Read port B architectural index |
| rd_data_b | output | DW | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write architectural index |
| wr_data | input | DW | Write data |
| save | input | 1 | Call strobe: slide window forward |
| restore | input | 1 | Return strobe: slide window back |
| overflow | output | 1 | Spill in progress; spill word valid |
| underflow | output | 1 | Fill in progress; fill words wanted |
| xfer_idx | output | 4 | Index of the frame word being spilled or filled |
| spill_data | output | DW | Spilled frame word |
| fill_valid | input | 1 | Fill word present |
| fill_data | input | DW | Fill word |
| cwp | output | $clog2(NWIN) | Current-window pointer |

## Verification
The bound checker watches the parts of the protocol that can be judged cycle by cycle. It checks that `xfer_idx` steps by one through a spill, that `cwp` holds during transfers and moves by one when they finish, and that fill gaps stall the counter. It also checks that strobes cannot start anything while a flag is high, that index 0 reads zero, and that the write-through bypass works. Other behaviour needs whole call sequences, so only the bench scenarios show it. This covers argument passing across a save, globals that stay the same across frames, and the content of each spilled word matching the oldest frame. It also covers filled words reappearing as the caller's registers, and correct data after frames have been spilled and refilled many windows deep.

// File: rtl/winreg_pkg.sv
package winreg_pkg;
  localparam int ARCH_W    = 5;
  localparam int GRP_REGS  = 8;
  localparam int SLOT_REGS = 2 * GRP_REGS;
  localparam int XFER_W    = $clog2(SLOT_REGS);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2
  } wr_state_e;

  typedef enum logic [1:0] {
    GRP_GLOB = 2'd0,
    GRP_OUT  = 2'd1,
    GRP_LOC  = 2'd2,
    GRP_IN   = 2'd3
  } reg_grp_e;
endpackage

// File: rtl/winreg_xlate.sv
module winreg_xlate
  import winreg_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int WIN_W = 3,
  parameter int PW    = 8
) (
  input  logic [WIN_W-1:0]  cwp,
  input  logic [ARCH_W-1:0] arch,
  output logic [PW-1:0]     phys
);
  localparam int GLOB_BASE = NWIN * SLOT_REGS;

  reg_grp_e         grp;
  logic [2:0]       k;
  logic [WIN_W-1:0] nxt;

  always_comb begin
    grp = reg_grp_e'(arch[4:3]);
    k   = arch[2:0];
    nxt = cwp + WIN_W'(1);
    case (grp)
      GRP_GLOB: phys = PW'(GLOB_BASE) + PW'(k);
      GRP_OUT:  phys = PW'({nxt, 1'b1, k});
      GRP_LOC:  phys = PW'({cwp, 1'b0, k});
      default:  phys = PW'({cwp, 1'b1, k});
    endcase
  end
endmodule

// File: rtl/winreg_store.sv
module winreg_store #(
  parameter int DW    = 32,
  parameter int NPHYS = 136,
  parameter int PW    = 8,
  parameter int NRD   = 3
) (
  input  logic                    clk,
  input  logic                    we_a,
  input  logic [PW-1:0]           wa_a,
  input  logic [DW-1:0]           wd_a,
  input  logic                    we_f,
  input  logic [PW-1:0]           wa_f,
  input  logic [DW-1:0]           wd_f,
  input  logic [NRD-1:0][PW-1:0]  ra,
  output logic [NRD-1:0][DW-1:0]  rd
);
  logic [DW-1:0] mem [NPHYS];

  always_ff @(posedge clk) begin
    if (we_a) mem[wa_a] <= wd_a;
    if (we_f) mem[wa_f] <= wd_f;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rd[g] = (we_a && (wa_a == ra[g])) ? wd_a : mem[ra[g]];
  end
endmodule

// File: rtl/winreg_ctrl.sv
module winreg_ctrl
  import winreg_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int WIN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              save,
  input  logic              restore,
  input  logic              fill_valid,
  output wr_state_e         state,
  output logic [WIN_W-1:0]  cwp,
  output logic [XFER_W-1:0] cnt,
  output logic [WIN_W-1:0]  spill_slot,
  output logic [WIN_W-1:0]  fill_slot
);
  localparam logic [WIN_W-1:0]  FULL = WIN_W'(NWIN - 1);
  localparam logic [XFER_W-1:0] LAST = XFER_W'(SLOT_REGS - 1);

  logic [WIN_W-1:0] res;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cwp   <= '0;
      res   <= WIN_W'(1);
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (save) begin
            if (res == FULL) begin
              state <= ST_SPILL;
            end else begin
              cwp <= cwp + WIN_W'(1);
              res <= res + WIN_W'(1);
            end
          end else if (restore) begin
            if (res == WIN_W'(1)) begin
              state <= ST_FILL;
            end else begin
              cwp <= cwp - WIN_W'(1);
              res <= res - WIN_W'(1);
            end
          end
        end
        ST_SPILL: begin
          cnt <= cnt + XFER_W'(1);
          if (cnt == LAST) begin
            state <= ST_IDLE;
            cwp   <= cwp + WIN_W'(1);
          end
        end
        ST_FILL: begin
          if (fill_valid) begin
            cnt <= cnt + XFER_W'(1);
            if (cnt == LAST) begin
              state <= ST_IDLE;
              cwp   <= cwp - WIN_W'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign spill_slot = cwp - (res - WIN_W'(1));
  assign fill_slot  = cwp - WIN_W'(1);
endmodule

// File: rtl/winreg_file.sv
module winreg_file
  import winreg_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NWIN = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4:0]              rd_addr_a,
  output logic [DW-1:0]           rd_data_a,
  input  logic [4:0]              rd_addr_b,
  output logic [DW-1:0]           rd_data_b,
  input  logic                    wr_en,
  input  logic [4:0]              wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic                    save,
  input  logic                    restore,
  output logic                    overflow,
  output logic                    underflow,
  output logic [3:0]              xfer_idx,
  output logic [DW-1:0]           spill_data,
  input  logic                    fill_valid,
  input  logic [DW-1:0]           fill_data,
  output logic [$clog2(NWIN)-1:0] cwp
);
  localparam int WIN_W  = $clog2(NWIN);
  localparam int NPHYS  = NWIN * SLOT_REGS + GRP_REGS;
  localparam int PW     = $clog2(NPHYS);
  localparam int NARCH  = 3;
  localparam int NRD    = 3;

  wr_state_e                  state;
  logic [XFER_W-1:0]          cnt;
  logic [WIN_W-1:0]           spill_slot;
  logic [WIN_W-1:0]           fill_slot;
  logic [NARCH-1:0][4:0]      arch_addr;
  logic [NARCH-1:0][PW-1:0]   arch_phys;
  logic [NRD-1:0][PW-1:0]     rd_phys;
  logic [NRD-1:0][DW-1:0]     rd_word;
  logic                       we_arch;
  logic                       we_fill;

  winreg_ctrl #(.NWIN(NWIN), .WIN_W(WIN_W)) ctrl_i (
    .clk        (clk),
    .rst        (rst),
    .save       (save),
    .restore    (restore),
    .fill_valid (fill_valid),
    .state      (state),
    .cwp        (cwp),
    .cnt        (cnt),
    .spill_slot (spill_slot),
    .fill_slot  (fill_slot)
  );

  assign arch_addr = {wr_addr, rd_addr_b, rd_addr_a};

  for (genvar g = 0; g < NARCH; g++) begin : g_xlate
    winreg_xlate #(.NWIN(NWIN), .WIN_W(WIN_W), .PW(PW)) xlate_i (
      .cwp  (cwp),
      .arch (arch_addr[g]),
      .phys (arch_phys[g])
    );
  end

  assign rd_phys = {PW'({spill_slot, cnt}), arch_phys[1], arch_phys[0]};
  assign we_arch = wr_en && (wr_addr != 5'd0);
  assign we_fill = (state == ST_FILL) && fill_valid;

  winreg_store #(.DW(DW), .NPHYS(NPHYS), .PW(PW), .NRD(NRD)) store_i (
    .clk  (clk),
    .we_a (we_arch),
    .wa_a (arch_phys[2]),
    .wd_a (wr_data),
    .we_f (we_fill),
    .wa_f (PW'({fill_slot, cnt})),
    .wd_f (fill_data),
    .ra   (rd_phys),
    .rd   (rd_word)
  );

  assign rd_data_a  = (rd_addr_a == 5'd0) ? '0 : rd_word[0];
  assign rd_data_b  = (rd_addr_b == 5'd0) ? '0 : rd_word[1];
  assign spill_data = rd_word[2];
  assign overflow   = (state == ST_SPILL);
  assign underflow  = (state == ST_FILL);
  assign xfer_idx   = 4'(cnt);
endmodule

// File: rtl/winreg_file_chk.sv
module winreg_file_chk #(
  parameter int DW    = 32,
  parameter int WIN_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             save,
  input logic             restore,
  input logic             fill_valid,
  input logic             overflow,
  input logic             underflow,
  input logic [3:0]       xfer_idx,
  input logic [WIN_W-1:0] cwp,
  input logic [4:0]       rd_addr_a,
  input logic [DW-1:0]    rd_data_a,
  input logic             wr_en,
  input logic [4:0]       wr_addr,
  input logic [DW-1:0]    wr_data
);
  assert_g0_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_addr_a == 5'd0) |-> (rd_data_a == '0));

  assert_bypass_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr != 5'd0 && wr_addr == rd_addr_a) |-> (rd_data_a == wr_data));

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
    !(overflow && underflow));

  assert_spill_step_R5: assert property (@(posedge clk) disable iff (rst)
    (overflow && xfer_idx != 4'd15) |=>
      (overflow && xfer_idx == 4'($past(xfer_idx) + 4'd1) && $stable(cwp)));

  assert_spill_done_R5: assert property (@(posedge clk) disable iff (rst)
    (overflow && xfer_idx == 4'd15) |=>
      (!overflow && cwp == WIN_W'($past(cwp) + 1'b1)));

  assert_fill_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (underflow && !fill_valid) |=> (underflow && $stable(xfer_idx) && $stable(cwp)));

  assert_fill_done_R6: assert property (@(posedge clk) disable iff (rst)
    (underflow && fill_valid && xfer_idx == 4'd15) |=>
      (!underflow && cwp == WIN_W'($past(cwp) - 1'b1)));

  assert_save_step_R2: assert property (@(posedge clk) disable iff (rst)
    (!overflow && !underflow && save) |=>
      (overflow || cwp == WIN_W'($past(cwp) + 1'b1)));

  assert_restore_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!overflow && !underflow && restore && !save) |=>
      (underflow || cwp == WIN_W'($past(cwp) - 1'b1)));

  assert_no_restart_R7: assert property (@(posedge clk) disable iff (rst)
    (overflow && xfer_idx != 4'd15) |=> !underflow);
endmodule

bind winreg_file winreg_file_chk #(.DW(DW), .WIN_W($clog2(NWIN))) chk_i (
  .clk        (clk),
  .rst        (rst),
  .save       (save),
  .restore    (restore),
  .fill_valid (fill_valid),
  .overflow   (overflow),
  .underflow  (underflow),
  .xfer_idx   (xfer_idx),
  .cwp        (cwp),
  .rd_addr_a  (rd_addr_a),
  .rd_data_a  (rd_data_a),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data)
);

// File: tb/winreg_file_tb_top.sv
module winreg_file_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAXD = 50;

  logic        clk = 1'b0;
  logic        rst;
  logic [4:0]  rd_addr_a, rd_addr_b, wr_addr;
  logic [31:0] rd_data_a, rd_data_b, wr_data, spill_data, fill_data;
  logic        wr_en, save, restore, fill_valid, overflow, underflow;
  logic [3:0]  xfer_idx;
  logic [2:0]  cwp;

  int n_checks = 0;
  int n_errs   = 0;

  logic [31:0] m_glob [8];
  bit          v_glob [8];
  logic [31:0] m_loc  [64][8];
  bit          v_loc  [64][8];
  logic [31:0] m_ins  [65][8];
  bit          v_ins  [65][8];
  int d     = 0;
  int res_m = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  winreg_file dut_i (
    .clk(clk), .rst(rst),
    .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
    .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .save(save), .restore(restore),
    .overflow(overflow), .underflow(underflow),
    .xfer_idx(xfer_idx), .spill_data(spill_data),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .cwp(cwp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic get_exp(input logic [4:0] a, output logic [31:0] val, output bit ok);
    int k = int'(a[2:0]);
    case (a[4:3])
      2'd0: begin
        if (a == 5'd0) begin val = '0; ok = 1'b1; end
        else begin val = m_glob[k]; ok = v_glob[k]; end
      end
      2'd1: begin val = m_ins[d+1][k]; ok = v_ins[d+1][k]; end
      2'd2: begin val = m_loc[d][k];   ok = v_loc[d][k];   end
      default: begin val = m_ins[d][k]; ok = v_ins[d][k]; end
    endcase
  endtask

  task automatic set_model(input logic [4:0] a, input logic [31:0] v);
    int k = int'(a[2:0]);
    case (a[4:3])
      2'd0: if (a != 5'd0) begin m_glob[k] = v; v_glob[k] = 1'b1; end
      2'd1: begin m_ins[d+1][k] = v; v_ins[d+1][k] = 1'b1; end
      2'd2: begin m_loc[d][k] = v;   v_loc[d][k] = 1'b1;   end
      default: begin m_ins[d][k] = v; v_ins[d][k] = 1'b1; end
    endcase
  endtask

  task automatic read_chk(input logic [4:0] a, input string req);
    logic [31:0] ea, eb;
    bit oka, okb;
    rd_addr_a = a;
    rd_addr_b = 5'd31 - a;
    #1;
    get_exp(rd_addr_a, ea, oka);
    get_exp(rd_addr_b, eb, okb);
    if (oka) chk(rd_data_a === ea, req, rd_data_a, ea);
    if (okb) chk(rd_data_b === eb, req, rd_data_b, eb);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    tick;
    wr_en = 1'b0;
    set_model(a, v);
  endtask

  task automatic chk_cwp(input string req);
    chk(cwp == 3'(d), req, 32'(cwp), 32'(3'(d)));
  endtask

  task automatic enter_frame;
    d++;
    for (int k = 0; k < 8; k++) begin
      v_loc[d][k] = 1'b0;
      v_ins[d+1][k] = 1'b0;
    end
  endtask

  task automatic do_save(input bit poke);
    save = 1'b1;
    tick;
    save = 1'b0;
    if (res_m == 7) begin
      int f = d - 6;
      chk(overflow === 1'b1, "R5 overflow raised", 32'(overflow), 32'd1);
      for (int i = 0; i < 16; i++) begin
        logic [31:0] e;
        bit ok;
        chk(xfer_idx == 4'(i), "R5 spill index", 32'(xfer_idx), 32'(i));
        if (i < 8) begin e = m_loc[f][i]; ok = v_loc[f][i]; end
        else begin e = m_ins[f][i-8]; ok = v_ins[f][i-8]; end
        if (ok) chk(spill_data === e, "R5 spill word", spill_data, e);
        if (poke && i == 5) begin save = 1'b1; restore = 1'b1; end
        tick;
        save = 1'b0; restore = 1'b0;
      end
      chk(overflow === 1'b0, "R5 overflow ends", 32'(overflow), 32'd0);
    end else begin
      chk(overflow === 1'b0, "R8 no spill needed", 32'(overflow), 32'd0);
      res_m++;
    end
    enter_frame();
    chk_cwp(poke ? "R7 save ignored during spill" : "R2 save cwp");
  endtask

  task automatic do_restore(input bit poke);
    restore = 1'b1;
    tick;
    restore = 1'b0;
    if (res_m == 1) begin
      int f = d - 1;
      chk(underflow === 1'b1, "R6 underflow raised", 32'(underflow), 32'd1);
      for (int i = 0; i < 16; i++) begin
        logic [31:0] w;
        while (($urandom % 4) == 0) begin
          fill_valid = 1'b0;
          tick;
          chk(underflow === 1'b1 && xfer_idx == 4'(i), "R6 fill gap holds",
              {27'd0, underflow, xfer_idx}, {27'd1, 4'(i)});
        end
        if (i < 8) begin
          if (!v_loc[f][i]) begin m_loc[f][i] = $urandom; v_loc[f][i] = 1'b1; end
          w = m_loc[f][i];
        end else begin
          if (!v_ins[f][i-8]) begin m_ins[f][i-8] = $urandom; v_ins[f][i-8] = 1'b1; end
          w = m_ins[f][i-8];
        end
        fill_valid = 1'b1;
        fill_data  = w;
        if (poke && i == 3) save = 1'b1;
        tick;
        save = 1'b0;
        fill_valid = 1'b0;
      end
      chk(underflow === 1'b0, "R6 underflow ends", 32'(underflow), 32'd0);
    end else begin
      chk(underflow === 1'b0, "R8 no fill needed", 32'(underflow), 32'd0);
      res_m--;
    end
    d--;
    chk_cwp(poke ? "R7 save ignored during fill" : "R2 restore cwp");
  endtask

  task automatic fill_frame;
    for (int a = 8; a < 32; a++) do_write(5'(a), $urandom);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_errs++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    save = 1'b0; restore = 1'b0; fill_valid = 1'b0; fill_data = '0;
    rd_addr_a = '0; rd_addr_b = '0;
    for (int x = 0; x < 64; x++)
      for (int k = 0; k < 8; k++) begin v_loc[x][k] = 1'b0; v_ins[x][k] = 1'b0; end
    for (int k = 0; k < 8; k++) begin v_glob[k] = 1'b0; v_ins[64][k] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    // R9 reset state
    chk(overflow === 1'b0, "R9 overflow after reset", 32'(overflow), 32'd0);
    chk(underflow === 1'b0, "R9 underflow after reset", 32'(underflow), 32'd0);
    chk(cwp == 3'd0, "R9 cwp after reset", 32'(cwp), 32'd0);
    read_chk(5'd0, "R3 g0 after reset");

    // R1/R2 globals and argument passing
    for (int a = 1; a < 32; a++) do_write(5'(a), $urandom);
    begin
      logic [31:0] outs [8];
      for (int k = 0; k < 8; k++) outs[k] = m_ins[1][k];
      do_save(1'b0);
      for (int a = 1; a < 8; a++) read_chk(5'(a), "R1 global same across windows");
      for (int k = 0; k < 8; k++) begin
        rd_addr_a = 5'(24 + k);
        #1;
        chk(rd_data_a === outs[k], "R2 caller outs are callee ins", rd_data_a, outs[k]);
      end
    end

    // R3 g0 write ignored
    do_write(5'd0, 32'hDEADBEEF);
    rd_addr_a = 5'd0; rd_addr_b = 5'd0;
    #1;
    chk(rd_data_a === 32'd0, "R3 g0 port A", rd_data_a, 32'd0);
    chk(rd_data_b === 32'd0, "R3 g0 port B", rd_data_b, 32'd0);

    // R4 write-through bypass
    wr_en = 1'b1; wr_addr = 5'd18; wr_data = 32'hA5A5_1234;
    rd_addr_a = 5'd18; rd_addr_b = 5'd18;
    #1;
    chk(rd_data_a === 32'hA5A5_1234, "R4 bypass port A", rd_data_a, 32'hA5A5_1234);
    chk(rd_data_b === 32'hA5A5_1234, "R4 bypass port B", rd_data_b, 32'hA5A5_1234);
    tick;
    wr_en = 1'b0;
    set_model(5'd18, 32'hA5A5_1234);

    // R7 save and restore together: save wins
    save = 1'b1; restore = 1'b1;
    tick;
    save = 1'b0; restore = 1'b0;
    chk(overflow === 1'b0 && underflow === 1'b0, "R7 both strobes no flag",
        {30'd0, overflow, underflow}, 32'd0);
    res_m++;
    enter_frame();
    chk_cwp("R7 save wins over restore");

    // Deep nesting: spills, then returns with fills
    for (int n = 0; n < 12; n++) begin
      fill_frame();
      do_save(n == 5);
      for (int a = 0; a < 32; a++) read_chk(5'(a), "R5 state after save");
    end
    for (int n = 0; n < 13; n++) begin
      do_restore(n == 10);
      for (int a = 0; a < 32; a++) read_chk(5'(a), "R6 filled frame reads back");
    end

    // Constrained random mix
    for (int it = 0; it < 900; it++) begin
      int op = $urandom % 10;
      if (op < 4) do_write(5'($urandom % 32), $urandom);
      else if (op < 6) read_chk(5'($urandom % 32), "R1 random read");
      else if (op < 8) begin
        if (d < MAXD) do_save(1'b0);
      end else begin
        if (d >= 1) do_restore(1'b0);
      end
    end
    for (int a = 0; a < 32; a++) read_chk(5'(a), "R8 final frame");

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule